// File: doc/BRIEF.md
# First-Ready Oldest-First Request Picker

This block sits between a memory request source and the per-bank command sequencers. It holds a small pool of pending requests, each with a target bank, a row, and a read or write flag. In every cycle it names at most one request for issue and removes that request from the pool at the next clock edge. The sequencers supply, for each bank, whether a row is open, which row that is, and whether the bank can take a command now.

In the default mode a request whose row equals the open row of its bank goes ahead of every request that needs a row command, even an older one. Age decides only among requests in the same hit class, so column commands come before row commands and the oldest wins within each group. A build-time parameter selects a plain arrival-order mode instead, in which the oldest eligible request always wins. A slot freed by a grant can take a new request in the same cycle.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset the pool is empty, `gnt_valid` is 0 and `enq_ready` is 1.
- R2: When `enq_valid` and `enq_ready` are both 1 at a clock edge, the request (`enq_bank`, `enq_row`, `enq_write`) enters the pool, and any later grant of it shows those same field values.
- R3: A request is eligible only when its bank's bit in `bank_ready` is 1. `gnt_valid` is 1 exactly when at least one pooled request is eligible.
- R4: A request is a row hit when `bank_open[b]` is 1 and `bank_open_row[b*ROW_W +: ROW_W]` equals its row, where b is its bank. In the default mode an eligible hit is always granted before any eligible non-hit.
- R5: In the default mode, among eligible requests of the same hit class the one accepted earliest is granted.
- R6: With `MODE = PICK_FCFS`, the earliest-accepted eligible request is granted whatever its hit status.
- R7: A granted request leaves the pool at that clock edge. Every accepted request is granted exactly once.
- R8: `enq_ready` is 0 only when all `DEPTH` slots are occupied and no grant is made in that cycle. A grant in a full cycle lets a new request in at the same edge.
- R9: `gnt_hit` is 1 when the granted request is a row hit (it becomes a column command) and 0 when it needs a row command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | New request offered |
| enq_bank | input | BANK_W | Target bank of the new request |
| enq_row | input | ROW_W | Target row of the new request |
| enq_write | input | 1 | 1 for write, 0 for read |
| enq_ready | output | 1 | Pool can accept a request this cycle |
| bank_ready | input | 2**BANK_W | Per-bank: can take a command now |
| bank_open | input | 2**BANK_W | Per-bank: a row is open |
| bank_open_row | input | 2**BANK_W*ROW_W | Per-bank open row, bank b at bits b*ROW_W upward |
| gnt_valid | output | 1 | A request is granted this cycle |
| gnt_bank | output | BANK_W | Bank of the granted request |
| gnt_row | output | ROW_W | Row of the granted request |
| gnt_write | output | 1 | Type of the granted request |
| gnt_hit | output | 1 | Granted request is a row hit |

## Verification
The assertions assume that the grant is always consumed in the cycle it is shown, that `enq_valid` is only counted when `enq_ready` is 1, and that the bank-state inputs are stable and known between clock edges. The bench drives every input only just after a falling edge and takes a grant as consumed in every cycle, so the pool never changes outside these assumptions. Bank readiness, open rows and request rows are all drawn from small value sets. This keeps row hits, full-pool stalls and grants into a full pool frequent across the load phases.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {
    PICK_FRFCFS = 1'b0,
    PICK_FCFS   = 1'b1
  } pick_mode_e;
endpackage

// File: rtl/sched_queue.sv
module sched_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enq_fire,
  input  logic [BANK_W-1:0]         enq_bank,
  input  logic [ROW_W-1:0]          enq_row,
  input  logic                      enq_write,
  input  logic [DEPTH-1:0]          deq_oh,
  output logic [DEPTH-1:0]          valid_o,
  output logic [DEPTH*BANK_W-1:0]   bank_o,
  output logic [DEPTH*ROW_W-1:0]    row_o,
  output logic [DEPTH-1:0]          wr_o,
  output logic [DEPTH*DEPTH-1:0]    older_o,
  output logic                      full_o
);
  logic [DEPTH-1:0]        valid_q, valid_d, free, enq_oh;
  logic [DEPTH*BANK_W-1:0] bank_q, bank_d;
  logic [DEPTH*ROW_W-1:0]  row_q, row_d;
  logic [DEPTH-1:0]        wr_q, wr_d;
  logic [DEPTH*DEPTH-1:0]  older_q, older_d;

  // slots free after this cycle's grant; lowest one takes the new request
  assign free   = ~(valid_q & ~deq_oh);
  assign enq_oh = enq_fire ? (free & (~free + 1'b1)) : '0;

  always_comb begin
    valid_d = (valid_q & ~deq_oh) | enq_oh;
    bank_d  = bank_q;
    row_d   = row_q;
    wr_d    = wr_q;
    older_d = older_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (enq_oh[i]) begin
        bank_d[i*BANK_W +: BANK_W] = enq_bank;
        row_d[i*ROW_W +: ROW_W]    = enq_row;
        wr_d[i]                    = enq_write;
      end
      for (int j = 0; j < DEPTH; j++) begin
        // older_q[i*DEPTH+j]: slot i arrived before slot j
        if (enq_oh[i])
          older_d[i*DEPTH+j] = 1'b0;
        else if (enq_oh[j])
          older_d[i*DEPTH+j] = (i != j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      wr_q    <= '0;
      older_q <= '0;
    end else begin
      valid_q <= valid_d;
      bank_q  <= bank_d;
      row_q   <= row_d;
      wr_q    <= wr_d;
      older_q <= older_d;
    end
  end

  assign valid_o = valid_q;
  assign bank_o  = bank_q;
  assign row_o   = row_q;
  assign wr_o    = wr_q;
  assign older_o = older_q;
  assign full_o  = &valid_q;

  p_enq_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |=> (($past(enq_oh) & ~valid_q) == '0));
  p_deq_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|deq_oh) |=> ((valid_q & $past(deq_oh & ~enq_oh)) == '0));
  p_deq_from_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((deq_oh & ~valid_q) == '0));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |-> (|(~valid_q | deq_oh)));
endmodule

// File: rtl/sched_hit.sv
module sched_hit #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic [DEPTH-1:0]           valid,
  input  logic [DEPTH*BANK_W-1:0]    bank,
  input  logic [DEPTH*ROW_W-1:0]     row,
  input  logic [NUM_BANKS-1:0]       bank_ready,
  input  logic [NUM_BANKS-1:0]       bank_open,
  input  logic [NUM_BANKS*ROW_W-1:0] bank_open_row,
  output logic [DEPTH-1:0]           elig_o,
  output logic [DEPTH-1:0]           hit_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [BANK_W-1:0] b;
    assign b         = bank[i*BANK_W +: BANK_W];
    assign elig_o[i] = valid[i] & bank_ready[b];
    assign hit_o[i]  = bank_open[b] &
                       (bank_open_row[b*ROW_W +: ROW_W] == row[i*ROW_W +: ROW_W]);
  end
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
  parameter int DEPTH = 8,
  parameter sched_pkg::pick_mode_e MODE = sched_pkg::PICK_FRFCFS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DEPTH-1:0]       elig,
  input  logic [DEPTH-1:0]       hit,
  input  logic [DEPTH*DEPTH-1:0] older,
  output logic [DEPTH-1:0]       grant_oh
);
  logic [DEPTH-1:0] cand;

  if (MODE == sched_pkg::PICK_FRFCFS) begin : g_frfcfs
    logic [DEPTH-1:0] elig_hit;
    assign elig_hit = elig & hit;
    assign cand     = (|elig_hit) ? elig_hit : elig;
    p_hit_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|grant_oh) && ((grant_oh & hit) == '0)) |-> ((elig & hit) == '0));
  end else begin : g_fcfs
    assign cand = elig;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        beaten = beaten | (cand[j] & older[j*DEPTH+i]);
      grant_oh[i] = cand[i] & ~beaten;
    end
  end

  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh));
  p_grant_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_oh & ~elig) == '0));
  p_grant_when_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |-> (|grant_oh));
endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter sched_pkg::pick_mode_e MODE = sched_pkg::PICK_FRFCFS,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enq_valid,
  input  logic [BANK_W-1:0]          enq_bank,
  input  logic [ROW_W-1:0]           enq_row,
  input  logic                       enq_write,
  output logic                       enq_ready,
  input  logic [NUM_BANKS-1:0]       bank_ready,
  input  logic [NUM_BANKS-1:0]       bank_open,
  input  logic [NUM_BANKS*ROW_W-1:0] bank_open_row,
  output logic                       gnt_valid,
  output logic [BANK_W-1:0]          gnt_bank,
  output logic [ROW_W-1:0]           gnt_row,
  output logic                       gnt_write,
  output logic                       gnt_hit
);
  logic [DEPTH-1:0]        valid, wr, elig, hit, grant_oh;
  logic [DEPTH*BANK_W-1:0] bank;
  logic [DEPTH*ROW_W-1:0]  row;
  logic [DEPTH*DEPTH-1:0]  older;
  logic                    full, enq_fire;

  assign enq_ready = ~full | gnt_valid;
  assign enq_fire  = enq_valid & enq_ready;

  sched_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .enq_fire(enq_fire), .enq_bank(enq_bank),
    .enq_row(enq_row), .enq_write(enq_write), .deq_oh(grant_oh),
    .valid_o(valid), .bank_o(bank), .row_o(row), .wr_o(wr),
    .older_o(older), .full_o(full));

  sched_hit #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_hit (
    .valid(valid), .bank(bank), .row(row), .bank_ready(bank_ready),
    .bank_open(bank_open), .bank_open_row(bank_open_row),
    .elig_o(elig), .hit_o(hit));

  sched_pick #(.DEPTH(DEPTH), .MODE(MODE)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .hit(hit), .older(older),
    .grant_oh(grant_oh));

  always_comb begin
    gnt_bank  = '0;
    gnt_row   = '0;
    gnt_write = 1'b0;
    gnt_hit   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant_oh[i]) begin
        gnt_bank  = gnt_bank | bank[i*BANK_W +: BANK_W];
        gnt_row   = gnt_row | row[i*ROW_W +: ROW_W];
        gnt_write = gnt_write | wr[i];
        gnt_hit   = gnt_hit | hit[i];
      end
    end
  end
  assign gnt_valid = |grant_oh;

  p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid == '0) |-> !gnt_valid);
  p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_ready) |-> ((&valid) && (elig == '0)));
endmodule

// File: tb/frfcfs_sched_bench.sv
`timescale 1ns/1ps
module frfcfs_sched_bench;
  localparam int DEPTH = 8;
  localparam int BW = 2;
  localparam int RW = 8;
  localparam int NB = 1 << BW;

  logic clk = 1'b0;
  logic rst_n;
  logic enq_valid, enq_write;
  logic [BW-1:0] enq_bank;
  logic [RW-1:0] enq_row;
  logic [NB-1:0] bank_ready, bank_open;
  logic [NB*RW-1:0] bank_open_row;

  logic          enq_ready_w [2];
  logic          gnt_valid_w [2];
  logic [BW-1:0] gnt_bank_w  [2];
  logic [RW-1:0] gnt_row_w   [2];
  logic          gnt_write_w [2];
  logic          gnt_hit_w   [2];

  always #2 clk = ~clk;

  frfcfs_sched #(.DEPTH(DEPTH), .BANK_W(BW), .ROW_W(RW),
                 .MODE(sched_pkg::PICK_FRFCFS)) u_frfcfs_sched (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_bank(enq_bank),
    .enq_row(enq_row), .enq_write(enq_write), .enq_ready(enq_ready_w[0]),
    .bank_ready(bank_ready), .bank_open(bank_open), .bank_open_row(bank_open_row),
    .gnt_valid(gnt_valid_w[0]), .gnt_bank(gnt_bank_w[0]), .gnt_row(gnt_row_w[0]),
    .gnt_write(gnt_write_w[0]), .gnt_hit(gnt_hit_w[0]));

  frfcfs_sched #(.DEPTH(DEPTH), .BANK_W(BW), .ROW_W(RW),
                 .MODE(sched_pkg::PICK_FCFS)) u_frfcfs_sched_fcfs (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_bank(enq_bank),
    .enq_row(enq_row), .enq_write(enq_write), .enq_ready(enq_ready_w[1]),
    .bank_ready(bank_ready), .bank_open(bank_open), .bank_open_row(bank_open_row),
    .gnt_valid(gnt_valid_w[1]), .gnt_bank(gnt_bank_w[1]), .gnt_row(gnt_row_w[1]),
    .gnt_write(gnt_write_w[1]), .gnt_hit(gnt_hit_w[1]));

  // reference pools, one per instance (0: hit-first, 1: arrival order)
  int m_v [2][DEPTH];
  int m_b [2][DEPTH];
  int m_r [2][DEPTH];
  int m_w [2][DEPTH];
  int m_s [2][DEPTH];
  int n_acc [2];
  int n_gnt [2];
  int seq;
  int n_chk, n_fail;
  bit done;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  function automatic int m_cnt(input int k);
    int c = 0;
    for (int i = 0; i < DEPTH; i++) c += m_v[k][i];
    return c;
  endfunction

  function automatic bit m_hit(input int k, input int i);
    int b = m_b[k][i];
    return bank_open[b] && (int'(bank_open_row[b*RW +: RW]) == m_r[k][i]);
  endfunction

  function automatic int m_pick(input int k);
    int best = -1;
    bit bh = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[k][i] != 0 && bank_ready[m_b[k][i]]) begin
        bit h = m_hit(k, i);
        if (best < 0) begin best = i; bh = h; end
        else if (k == 0 && h && !bh) begin best = i; bh = h; end
        else if ((k == 1 || h == bh) && m_s[k][i] < m_s[k][best]) begin best = i; bh = h; end
      end
    end
    return best;
  endfunction

  // compare one instance against its pool, then advance the pool
  task automatic step(input int k);
    int e = m_pick(k);
    bit rdy = (m_cnt(k) < DEPTH) || (e >= 0);
    string rq;
    chk(gnt_valid_w[k] == (e >= 0), "R3 grant present", gnt_valid_w[k], int'(e >= 0));
    chk(enq_ready_w[k] == rdy, "R8 enq_ready", enq_ready_w[k], rdy);
    if (e >= 0 && gnt_valid_w[k]) begin
      rq = (k == 1) ? "R6 oldest pick" : (m_hit(k, e) ? "R4 hit first" : "R5 oldest in class");
      chk(int'(gnt_bank_w[k]) == m_b[k][e], {rq, " bank (R2 fields)"}, gnt_bank_w[k], m_b[k][e]);
      chk(int'(gnt_row_w[k]) == m_r[k][e], {rq, " row (R2 fields)"}, gnt_row_w[k], m_r[k][e]);
      chk(int'(gnt_write_w[k]) == m_w[k][e], {rq, " write (R2 fields)"}, gnt_write_w[k], m_w[k][e]);
      chk(gnt_hit_w[k] == m_hit(k, e), "R9 hit flag", gnt_hit_w[k], m_hit(k, e));
    end
    if (e >= 0) begin m_v[k][e] = 0; n_gnt[k]++; end
    if (enq_valid && rdy) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (m_v[k][i] == 0) begin
          m_v[k][i] = 1; m_b[k][i] = enq_bank; m_r[k][i] = enq_row;
          m_w[k][i] = enq_write; m_s[k][i] = seq;
          break;
        end
      end
      n_acc[k]++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog expired: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; seq = 0; done = 0;
    for (int k = 0; k < 2; k++) begin
      n_acc[k] = 0; n_gnt[k] = 0;
      for (int i = 0; i < DEPTH; i++) m_v[k][i] = 0;
    end
    rst_n = 1'b0; enq_valid = 0; enq_bank = '0; enq_row = '0; enq_write = 0;
    bank_ready = '0; bank_open = '0; bank_open_row = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int k = 0; k < 2; k++) begin
      chk(gnt_valid_w[k] == 1'b0, "R1 reset grant", gnt_valid_w[k], 0);
      chk(enq_ready_w[k] == 1'b1, "R1 reset ready", enq_ready_w[k], 1);
    end

    for (int c = 0; c < 5000; c++) begin
      int ph = (c / 250) % 5;
      int rp = (ph == 0) ? 10 : (ph == 1) ? 50 : (ph == 2) ? 100 : (ph == 3) ? 35 : 0;
      int ep = (ph == 2) ? 30 : (ph == 1) ? 50 : 95;
      @(negedge clk);
      enq_valid = ($urandom_range(99) < ep);
      enq_bank  = BW'($urandom_range(NB - 1));
      enq_row   = RW'($urandom_range(3));
      enq_write = 1'($urandom_range(1));
      for (int b = 0; b < NB; b++) begin
        bank_ready[b] = ($urandom_range(99) < rp);
        bank_open[b]  = ($urandom_range(3) != 0);
        bank_open_row[b*RW +: RW] = RW'($urandom_range(3));
      end
      #1;
      step(0);
      step(1);
      seq++;
    end

    // drain: no new work, every bank ready
    for (int c = 0; c < DEPTH + 4; c++) begin
      @(negedge clk);
      enq_valid = 0;
      bank_ready = '1;
      #1;
      step(0);
      step(1);
      seq++;
    end
    for (int k = 0; k < 2; k++) begin
      chk(gnt_valid_w[k] == 1'b0, "R7 drained pool idle", gnt_valid_w[k], 0);
      chk(n_gnt[k] == n_acc[k], "R7 each request granted once", n_gnt[k], n_acc[k]);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule